// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, A and B, and moves data between them in one of two directions. Each direction owns a storage register that snapshots the source bus when its capture input rises. The capture inputs are sampled in the system clock domain. The port being driven shows either the live value of the opposite bus or the stored copy, and a separate source select exists for each direction.

The bus pins are split into an input, an output and an output-enable per side, so the pads can sit outside the block. Captures ignore the enable, direction and select inputs. Because of this the block can pass data straight through, hold a value and replay it later, or swap the contents of both buses through the two registers. The data outputs always carry the selected source. The output-enables decide whether a side actually drives its bus.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a clock edge where `cap_ab_i` is sampled high and was sampled low on the previous edge, the A-to-B register loads `a_i`.
- R2: On a clock edge where `cap_ba_i` is sampled high and was sampled low on the previous edge, the B-to-A register loads `b_i`.
- R3: A capture takes place whatever the values of `en_ni`, `dir_i`, `sel_ab_i` and `sel_ba_i`.
- R4: `b_o` equals `a_i` when `sel_ab_i` is 0 and equals the A-to-B register when `sel_ab_i` is 1.
- R5: `a_o` equals `b_i` when `sel_ba_i` is 0 and equals the B-to-A register when `sel_ba_i` is 1.
- R6: While `en_ni` is 1, both `a_oe_o` and `b_oe_o` are 0.
- R7: While `en_ni` is 0, `dir_i` = 1 gives `b_oe_o` = 1 and `a_oe_o` = 0, and `dir_i` = 0 gives `a_oe_o` = 1 and `b_oe_o` = 0.
- R8: Asserting `rst_ni` low clears both registers and both capture-edge detectors to 0.
- R9: A capture input held high loads its register once only. Later edges leave the register unchanged until the input has been sampled low again.
- R10: After a select changes, each data output holds exactly the value of one of its two sources, with no bitwise mix of the two.
- R11: When both capture inputs rise on the same edge, each register loads the value the other bus had before that edge, which exchanges the bus contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Transceiver enable, active low |
| dir_i | input | 1 | 1: drive B from the A side, 0: drive A from the B side |
| sel_ab_i | input | 1 | B-side source: 0 live A, 1 stored A-to-B register |
| sel_ba_i | input | 1 | A-side source: 0 live B, 1 stored B-to-A register |
| cap_ab_i | input | 1 | A-to-B capture strobe, rising edge |
| cap_ba_i | input | 1 | B-to-A capture strobe, rising edge |
| a_i | input | 8 | A bus input |
| a_o | output | 8 | A bus output data |
| a_oe_o | output | 1 | A bus output enable |
| b_i | input | 8 | B bus input |
| b_o | output | 8 | B bus output data |
| b_oe_o | output | 1 | B bus output enable |

## Verification
The assertions assume that the capture strobes and the bus inputs are synchronous to the system clock. They also assume these inputs are stable at each rising edge, so "sampled high after sampled low" is a clean edge. The bench changes every input on the falling clock edge. Each capture pulse is held high for exactly one rising edge, and the strobe is then sampled low for at least one edge before the next pulse. The hold test is the one exception: it keeps a strobe high on purpose to exercise R9.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned BUS_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef enum logic {
    DIR_B2A = 1'b0,
    DIR_A2B = 1'b1
  } dir_e;
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic cap_q;
  logic rise;

  assign rise = cap_i & ~cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      q_o   <= '0;
    end else begin
      cap_q <= cap_i;
      if (rise) q_o <= d_i;
    end
  end

  // R1 / R2: load on a detected rising strobe
  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !cap_q) |=> (q_o == $past(d_i)));

  // R9: no load without a fresh edge
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_i && !cap_q) |=> $stable(q_o));

  // R8: register is clear when reset releases
  a_r8_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (q_o == '0));
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_e         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] y_o
);
  logic pick_s;
  assign pick_s = (sel_i == SRC_STORED);

  // fully decoded AND-OR per bit: no state in which neither source is passed
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[i] = (pick_s & stored_i[i]) | (~pick_s & live_i[i]);
  end
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import xcvr_pkg::*;
(
  input  logic en_ni,
  input  dir_e dir_i,
  output logic a_oe_o,
  output logic b_oe_o
);
  always_comb begin
    a_oe_o = 1'b0;
    b_oe_o = 1'b0;
    if (!en_ni) begin
      unique case (dir_i)
        DIR_A2B: b_oe_o = 1'b1;
        DIR_B2A: a_oe_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] ab_q, ba_q;

  xcvr_capture #(.W(W)) u_cap_ab (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_ab_i), .d_i(a_i), .q_o(ab_q)
  );

  xcvr_capture #(.W(W)) u_cap_ba (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_ba_i), .d_i(b_i), .q_o(ba_q)
  );

  xcvr_src_mux #(.W(W)) u_mux_b (
    .sel_i(src_e'(sel_ab_i)), .live_i(a_i), .stored_i(ab_q), .y_o(b_o)
  );

  xcvr_src_mux #(.W(W)) u_mux_a (
    .sel_i(src_e'(sel_ba_i)), .live_i(b_i), .stored_i(ba_q), .y_o(a_o)
  );

  xcvr_drive_ctrl u_drv (
    .en_ni(en_ni), .dir_i(dir_e'(dir_i)), .a_oe_o(a_oe_o), .b_oe_o(b_oe_o)
  );

  // R6
  a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> (!a_oe_o && !b_oe_o));

  // R7
  a_r7_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ni |-> $onehot({a_oe_o, b_oe_o}) && (b_oe_o == dir_i));

  // R10: each output is exactly one of its sources
  a_r10_b_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_o == a_i) || (b_o == ab_q));
  a_r10_a_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_o == b_i) || (a_o == ba_q));

  // R11: simultaneous strobes exchange the buses
  a_r11_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_ab_i && !$past(cap_ab_i) && cap_ba_i && !$past(cap_ba_i) && !$rose(rst_ni))
    |=> (ab_q == $past(a_i)) && (ba_q == $past(b_i)));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 8;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_ni = 1'b1, dir_i = 1'b0, sel_ab_i = 1'b0, sel_ba_i = 1'b0;
  logic cap_ab_i = 1'b0, cap_ba_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic a_oe_o, b_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .dir_i(dir_i),
    .sel_ab_i(sel_ab_i), .sel_ba_i(sel_ba_i), .cap_ab_i(cap_ab_i), .cap_ba_i(cap_ba_i),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o), .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  // {en_n, dir, sel_ab, sel_ba, cap_ab, cap_ba, a, b}
  localparam logic [21:0] TBL [NV] = '{
    {6'b010000, 8'h3C, 8'hA5},
    {6'b000000, 8'h3C, 8'hA5},
    {6'b110010, 8'h5A, 8'h11},  // R3 capture while disabled
    {6'b011000, 8'hFF, 8'h22},
    {6'b100001, 8'h77, 8'hC3},  // R3
    {6'b000100, 8'h00, 8'h99},
    {6'b011111, 8'h81, 8'h7E},  // R11 swap
    {6'b001100, 8'h00, 8'h00},
    {6'b011000, 8'h13, 8'h24},
    {6'b000110, 8'hF0, 8'h0F},
    {6'b011000, 8'h00, 8'h00},
    {6'b101100, 8'hAA, 8'h55},
    {6'b010101, 8'h66, 8'hEE},
    {6'b000100, 8'h01, 8'h02},
    {6'b010000, 8'hC7, 8'h8B},
    {6'b001001, 8'h00, 8'hBD}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] exp_b, exp_a;
    exp_b = sel_ab_i ? m_ab : a_i;
    exp_a = sel_ba_i ? m_ba : b_i;
    chk({tag, " R4 b_o"}, b_o, exp_b);
    chk({tag, " R5 a_o"}, a_o, exp_a);
    chk({tag, " R6/R7 a_oe"}, {7'b0, a_oe_o}, {7'b0, !en_ni && !dir_i});
    chk({tag, " R6/R7 b_oe"}, {7'b0, b_oe_o}, {7'b0, !en_ni && dir_i});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R8 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    en_ni = 1'b0; dir_i = 1'b1; sel_ab_i = 1'b1; sel_ba_i = 1'b1;
    a_i = 8'hFF; b_i = 8'hFF;
    #1;
    chk("R8 ab after reset", b_o, 8'h00);
    chk("R8 ba after reset", a_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {en_ni, dir_i, sel_ab_i, sel_ba_i, cap_ab_i, cap_ba_i, a_i, b_i} = TBL[i];
      @(posedge clk);
      if (cap_ab_i) m_ab = a_i;  // R1
      if (cap_ba_i) m_ba = b_i;  // R2
      @(negedge clk);
      cap_ab_i = 1'b0; cap_ba_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      #1;
      check_all($sformatf("vec%0d R1/R2/R3/R11", i));
    end

    // R9: strobe held high loads once
    @(negedge clk);
    sel_ab_i = 1'b1; a_i = 8'h42; cap_ab_i = 1'b1;
    @(posedge clk);
    m_ab = 8'h42;
    @(negedge clk); a_i = 8'h99;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R9 held strobe", b_o, 8'h42);
    cap_ab_i = 1'b0;
    @(posedge clk);
    @(negedge clk); a_i = 8'h5C; cap_ab_i = 1'b1;
    @(posedge clk);
    @(negedge clk); cap_ab_i = 1'b0; #1;
    chk("R9 re-arm after low", b_o, 8'h5C);
    m_ab = 8'h5C;

    // R10: select toggles land directly on the new source
    @(negedge clk);
    a_i = 8'hA3; sel_ab_i = 1'b0; #1;
    chk("R10 to live", b_o, 8'hA3);
    sel_ab_i = 1'b1; #1;
    chk("R10 to stored", b_o, 8'h5C);
    b_i = 8'h3A; sel_ba_i = 1'b0; #1;
    chk("R10 a to live", a_o, 8'h3A);

    // R8: mid-run reset clears stored data
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    sel_ab_i = 1'b1; sel_ba_i = 1'b1; #1;
    chk("R8 ab cleared", b_o, 8'h00);
    chk("R8 ba cleared", a_o, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule